// File: doc/BRIEF.md
# Sign-Copy and Integer Repositioning Unit

This unit sits in the execute stage of a 64-bit floating-point register datapath. It handles the operations that move bits without interpreting them. Three operations merge the sign field, or the sign and exponent fields, of one operand with the rest of a second operand; one of them inverts the copied sign. The other two move integers between a full 64-bit quadword and the scattered 32-bit longword layout that floating registers use.

Each accepted operation is registered once. The result, a valid flag and an integer-overflow trap flag appear one cycle after the input strobe. No operand is checked for special floating values, so these operations never trap on them. The only trap is the optional overflow check on the quadword-to-longword move.

Function select encoding: 0 = copy sign, 1 = copy negated sign, 2 = copy sign and exponent, 3 = quadword to longword, 4 = longword to quadword, 5 to 7 unused.

Top module: `fp_bitmove_unit`

## Requirements
- R1: With func 0, the result is op_a[63] followed by op_b[62:0].
- R2: With func 1, the result is the inverted op_a[63] followed by op_b[62:0].
- R3: With func 2, the result is op_a[63:52] followed by op_b[51:0].
- R4: With func 3, the result from most to least significant is op_b[31:30], three zeros, op_b[29:0], then 29 zeros. This layout is written whether or not overflow occurs.
- R5: With func 4, the result is the 64-bit sign extension of the 32-bit value {op_b[63:62], op_b[58:29]}.
- R6: With func 3, ovf_trap is set exactly when op_b, read as a signed number, lies outside -2^31 to 2^31-1 and ovf_en is 1.
- R7: Every accepted operation other than func 3 clears ovf_trap.
- R8: Func codes 5, 6 and 7 give an all-zero result and no trap.
- R9: result, ovf_trap and out_valid update on the clock edge that samples in_valid high. out_valid is high for exactly one cycle per accepted strobe.
- R10: While in_valid is low, result and ovf_trap keep their values.
- R11: During reset (rst_n low), result is zero and out_valid and ovf_trap are low.
- R12: Operands holding non-finite patterns, such as all-ones exponents, pass through with no trap for funcs 0, 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation strobe |
| func | input | 3 | Function select |
| ovf_en | input | 1 | Enables the overflow trap on func 3 |
| op_a | input | 64 | Sign/exponent source operand |
| op_b | input | 64 | Main operand |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| result | output | 64 | Registered result |
| ovf_trap | output | 1 | Integer-overflow trap flag |

## Verification
The assertions assume that in_valid, func and ovf_en are driven to known values at every clock edge after reset. They also assume that in_valid is low while reset is held. The bench meets both conditions by changing inputs only on the falling edge and holding in_valid low through reset. Random cycles mix strobe and idle cycles and cover all eight function codes. Directed cases sit exactly on both sides of the signed 32-bit range, with the overflow enable both on and off.

// File: rtl/fp_bitmove_unit.sv
module fp_bitmove_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  func,
  input  logic        ovf_en,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        ovf_trap
);
  localparam logic [2:0] F_CPS  = 3'd0;
  localparam logic [2:0] F_CPSN = 3'd1;
  localparam logic [2:0] F_CPSE = 3'd2;
  localparam logic [2:0] F_Q2L  = 3'd3;
  localparam logic [2:0] F_L2Q  = 3'd4;

  logic [63:0] nxt;
  logic        q_ovf;

  // out of signed 32-bit range when the upper 33 bits disagree
  assign q_ovf = !((&op_b[63:31]) || !(|op_b[63:31]));

  always_comb begin
    case (func)
      F_CPS:   nxt = {op_a[63], op_b[62:0]};
      F_CPSN:  nxt = {~op_a[63], op_b[62:0]};
      F_CPSE:  nxt = {op_a[63:52], op_b[51:0]};
      F_Q2L:   nxt = {op_b[31:30], 3'b000, op_b[29:0], 29'd0};
      F_L2Q:   nxt = {{32{op_b[63]}}, op_b[63:62], op_b[58:29]};
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_trap  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt;
        ovf_trap <= (func == F_Q2L) && q_ovf && ovf_en;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_trap_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf_en) |=> !ovf_trap);
  a_r7_trap_only_q2l: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func != F_Q2L) |=> !ovf_trap);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ovf_trap)));
  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func == F_Q2L) |=> (result[28:0] == 29'd0));
  a_r3_fraction: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func == F_CPSE) |=> (result[51:0] == $past(op_b[51:0])));
endmodule

// File: tb/fp_bitmove_unit_tb.sv
module fp_bitmove_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [2:0]  func = 0;
  logic        ovf_en = 0;
  logic [63:0] op_a = 0;
  logic [63:0] op_b = 0;
  logic        out_valid;
  logic [63:0] result;
  logic        ovf_trap;
  int checks = 0;
  int errors = 0;
  logic [63:0] exp_res = 0;
  logic        exp_trap = 0;

  always #10 clk = ~clk;

  fp_bitmove_unit u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func),
    .ovf_en(ovf_en), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .result(result), .ovf_trap(ovf_trap));

  function automatic logic [63:0] model(input logic [2:0] f, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic [31:0] lw;
    r = 0;
    case (f)
      3'd0: begin r = b; r[63] = a[63]; end
      3'd1: begin r = b; r[63] = !a[63]; end
      3'd2: begin r = b; r[63:52] = a[63:52]; end
      3'd3: begin r[63:62] = b[31:30]; r[58:29] = b[29:0]; end
      3'd4: begin lw = {b[63:62], b[58:29]}; r = 64'($signed(lw)); end
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic logic overflows(input logic [63:0] b);
    return ($signed(b) > 64'sd2147483647) || ($signed(b) < -64'sd2147483648);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] f, input logic en,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1; func = f; ovf_en = en; op_a = a; op_b = b;
    exp_res = model(f, a, b);
    exp_trap = (f == 3'd3) && en && overflows(b);
    @(posedge clk); #2;
    check({req, " result"}, result, exp_res);
    check({req, " trap R6/R7"}, {63'd0, ovf_trap}, {63'd0, exp_trap});
    check({req, " valid R9"}, {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    in_valid = 0;
    func = 3'($urandom_range(0, 7)); op_b = {$urandom, $urandom}; ovf_en = 1;
    @(posedge clk); #2;
    check("R10 hold result", result, exp_res);
    check("R10 hold trap", {63'd0, ovf_trap}, {63'd0, exp_trap});
    check("R9 valid drop", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #35;
    check("R11 reset result", result, 64'd0);
    check("R11 reset valid", {63'd0, out_valid}, 64'd0);
    check("R11 reset trap", {63'd0, ovf_trap}, 64'd0);
    @(negedge clk); rst_n = 1;

    run_op("R1", 3'd0, 1, 64'h8000_0000_0000_0000, 64'h7FF0_1234_5678_9ABC);
    run_op("R2", 3'd1, 1, 64'h8000_0000_0000_0000, 64'hFFF8_0000_0000_0001);
    run_op("R3", 3'd2, 1, 64'hABCD_EF01_2345_6789, 64'h0123_4567_89AB_CDEF);
    run_op("R4 max", 3'd3, 1, 64'h0, 64'h0000_0000_7FFF_FFFF);
    run_op("R4 R6 max+1", 3'd3, 1, 64'h0, 64'h0000_0000_8000_0000);
    run_op("R4 min", 3'd3, 1, 64'h0, 64'hFFFF_FFFF_8000_0000);
    run_op("R6 min-1", 3'd3, 1, 64'h0, 64'hFFFF_FFFF_7FFF_FFFF);
    run_op("R6 disabled", 3'd3, 0, 64'h0, 64'h1234_5678_9ABC_DEF0);
    run_op("R7 clear", 3'd4, 1, 64'h0, 64'hC000_0000_2000_0000);
    run_op("R5 neg", 3'd4, 1, 64'h0, 64'h8000_0000_0000_0000);
    run_op("R12 nan", 3'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
    run_op("R8 code5", 3'd5, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R4 R6 set", 3'd3, 1, 64'h0, 64'h7000_0000_0000_0001);
    run_op("R8 R7 code7", 3'd7, 1, 64'h1, 64'h1);
    for (int i = 0; i < 300; i++) begin
      logic [63:0] b;
      b = {$urandom, $urandom};
      if (i % 3 == 0) b = 64'($signed(32'($urandom)));
      run_op("R1-rand", 3'($urandom_range(0, 7)), 1'($urandom), {$urandom, $urandom}, b);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule